// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block is a clocked controller for an asynchronous extended-data-out DRAM. It owns the row strobe, the column strobe, the write strobe and the row address pins. It has two jobs: bringing the memory up safely, and keeping it refreshed. After reset it keeps the memory bus quiet for a stabilisation interval. It then runs a burst of wake-up refresh cycles. Only after that burst does it report the memory as ready.

In normal operation the block schedules one distributed refresh per refresh interval. It shares the memory with a host through a request/grant handshake. A grant is given only when the memory is ready and no refresh is due. A refresh that falls due during a host cycle is served as soon as the host lets go.

If a host cycle runs so long that a refresh misses its deadline, the block sets a sticky overrun flag and withdraws ready. Once the host releases, the block replays the full wake-up burst. Each refresh cycle uses one of two styles, chosen per cycle by an input:
- row-only: the block drives the row address from its own wrapping row counter.
- column-before-row: the memory's internal counter supplies the row, so no address is driven.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and for at least PAUSE_CYC cycles after it is released, ready, host_gnt and overrun are 0 and ras_n, cas_n and we_n are 1.
- R2: When the pause has elapsed, exactly WAKE_CYCLES refresh cycles (ras_n low pulses) are issued, and then ready goes to 1.
- R3: A refresh that starts while cbr_mode is 0 is a row-only cycle: ras_n is low for exactly RAS_LOW_CYC cycles and cas_n stays 1 for the whole pulse.
- R4: A refresh that starts while cbr_mode is 1 is a column-before-row cycle. In this cycle:
  - cas_n falls CAS_LEAD_CYC cycles before ras_n.
  - cas_n stays low for exactly CAS_LOW_CYC cycles.
  - ras_n is low for RAS_LOW_CYC cycles.
  - row_addr reads 0 when ras_n falls.
- R5: The row counter starts at 0 after reset. row_addr shows its value when a row-only ras_n pulse falls. The counter then advances by one, wrapping from ROWS-1 to 0. Column-before-row cycles leave it unchanged.
- R6: we_n is 1 at all times, including during every refresh cycle.
- R7: While ready and no host is granted, successive refresh cycles of the same style begin exactly REF_INTERVAL cycles apart.
- R8: The host grant follows these rules:
  - host_gnt rises only in a cycle that follows a cycle with ready at 1.
  - While host_gnt is 1, ras_n and cas_n stay 1.
  - host_gnt stays 1 while host_req is held.
  - host_gnt falls one cycle after host_req drops.
- R9: A refresh that falls due while the host is granted is issued before the next grant, even if host_req is raised again immediately after release.
- R10: A missed refresh deadline is handled as follows:
  - If DEADLINE_CYC cycles pass after a refresh start with no new refresh start, overrun goes to 1 and ready goes to 0.
  - After the host releases, exactly WAKE_CYCLES refresh cycles are replayed.
  - overrun then returns to 0 in the same cycle that ready returns to 1.
  - Host cycles that end within the deadline never set overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cbr_mode | input | 1 | Refresh style sampled at each refresh start: 1 column-before-row, 0 row-only |
| host_req | input | 1 | Host asks for the memory and holds this high for the whole host cycle |
| host_gnt | output | 1 | Memory granted to the host |
| ready | output | 1 | Wake-up complete and no overrun outstanding |
| overrun | output | 1 | Sticky flag: a refresh deadline was missed; cleared by the replayed wake-up |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | $clog2(ROWS) | Refresh row during row-only cycles, otherwise 0 |

## Verification
The hardest situation to reach from the ports is a missed refresh deadline. The bench reaches it by holding one grant far past DEADLINE_CYC, then counting the replayed wake-up pulses after release. A second difficult case is a refresh falling due inside a host cycle: a directed grant is held just past REF_INTERVAL and the request is re-raised at once, to show that the refresh wins. Random host traffic with random refresh styles is kept inside the deadline. During this traffic the bench tracks the expected row sequence across mixed styles and wraps of the row counter.

// File: rtl/dref_pkg.sv
// Shared types for the DRAM power-up and refresh sequencer.
// Assumes: used by every module of the sequencer; holds no state.
package dref_pkg;

    // Top-level controller phases.
    typedef enum logic [2:0] {
        ST_PAUSE   = 3'd0,  // stabilisation wait after reset
        ST_WAKE    = 3'd1,  // wake-up refresh burst
        ST_RUN     = 3'd2,  // ready, idle
        ST_HOST    = 3'd3,  // memory granted to host
        ST_REFRESH = 3'd4   // distributed refresh in progress
    } seq_state_t;

    // Larger of two cycle counts.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_sat_counter.sv
// Saturating up-counter for interval timing.
// Counts one per enabled cycle and sticks at all-ones.
// Assumes: clear wins over enable; WIDTH is sized by the user so that
// saturation lies beyond every compare value.
module dref_sat_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [WIDTH-1:0] count
);

    // Count with clear and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dref_row_counter.sv
// Refresh row counter for row-only refresh cycles.
// Advances by one per step and wraps from ROWS-1 to 0.
// Assumes: step is a single-cycle pulse issued at the end of a row-only cycle.
module dref_row_counter #(
    parameter int ROWS  = 2048,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    // Advance and wrap the row pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= (row == LAST_ROW) ? '0 : row + 1'b1;
        end
    end

    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row <= LAST_ROW);                                          // R5
    AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(row));                                   // R5

endmodule

// File: rtl/dref_cycle_gen.sv
// Generates one refresh cycle on the DRAM strobes per start pulse.
// Row-only style: the row strobe is low for RAS_LOW_CYC cycles and
// row_out carries the refresh row.
// Column-before-row style: the column strobe falls first, the row
// strobe follows CAS_LEAD_CYC cycles later, and row_out is 0.
// Each cycle ends with PRECHARGE_CYC high cycles.
// Strobe outputs are registered, one cycle behind the phase counter.
// Assumes: start is raised only while busy is 0; CAS_LOW_CYC > CAS_LEAD_CYC;
// PRECHARGE_CYC >= 1.
module dref_cycle_gen #(
    parameter int RAS_LOW_CYC   = 15,
    parameter int CAS_LOW_CYC   = 5,
    parameter int CAS_LEAD_CYC  = 2,
    parameter int PRECHARGE_CYC = 10,
    parameter int ROW_W         = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cbr,
    input  logic [ROW_W-1:0] row_in,
    output logic             busy,
    output logic             done,
    output logic             kind_cbr,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row_out
);
    import dref_pkg::*;

    localparam int TOT_RO  = RAS_LOW_CYC + PRECHARGE_CYC;
    localparam int TOT_CBR = max_int(CAS_LEAD_CYC + RAS_LOW_CYC, CAS_LOW_CYC) + PRECHARGE_CYC;
    localparam int TOT_MAX = max_int(TOT_RO, TOT_CBR);
    localparam int TW      = $clog2(TOT_MAX + 1);

    localparam logic [TW-1:0] LAST_RO   = TW'(TOT_RO - 1);
    localparam logic [TW-1:0] LAST_CBR  = TW'(TOT_CBR - 1);
    localparam logic [TW-1:0] T_RAS     = TW'(RAS_LOW_CYC);
    localparam logic [TW-1:0] T_CAS     = TW'(CAS_LOW_CYC);
    localparam logic [TW-1:0] T_LEAD    = TW'(CAS_LEAD_CYC);
    localparam logic [TW-1:0] T_CBR_END = TW'(CAS_LEAD_CYC + RAS_LOW_CYC);

    logic [TW-1:0] phase;
    logic          ras_low_d;
    logic          cas_low_d;
    logic [TW-1:0] last_phase;

    assign kind_cbr   = busy && busy_cbr_q;
    assign last_phase = busy_cbr_q ? LAST_CBR : LAST_RO;
    assign done       = busy && (phase == last_phase);

    logic busy_cbr_q;

    // Phase counter and style latch for the cycle in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            phase      <= '0;
            busy_cbr_q <= 1'b0;
        end else if (start) begin
            busy       <= 1'b1;
            phase      <= '0;
            busy_cbr_q <= cbr;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Decode strobe levels from the current phase.
    always_comb begin
        ras_low_d = 1'b0;
        cas_low_d = 1'b0;
        if (busy) begin
            if (busy_cbr_q) begin
                cas_low_d = (phase < T_CAS);
                ras_low_d = (phase >= T_LEAD) && (phase < T_CBR_END);
            end else begin
                ras_low_d = (phase < T_RAS);
            end
        end
    end

    // Register strobes and address so the pins never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n   <= 1'b1;
            cas_n   <= 1'b1;
            row_out <= '0;
        end else begin
            ras_n   <= !ras_low_d;
            cas_n   <= !cas_low_d;
            row_out <= (busy && !busy_cbr_q) ? row_in : '0;
        end
    end

    // Low-run lengths of the strobe pins, kept for the width checks below.
    logic [TW-1:0] ras_run;
    logic [TW-1:0] cas_run;

    // Measure how long each strobe has been low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_run <= '0;
            cas_run <= '0;
        end else begin
            ras_run <= ras_n ? '0 : ras_run + 1'b1;
            cas_run <= cas_n ? '0 : cas_run + 1'b1;
        end
    end

    AST_RAS_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_run == T_RAS));                      // R3
    AST_CAS_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (cas_run == T_CAS));                      // R4
    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ras_n);                                   // R4
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);                                          // R2

endmodule

// File: rtl/dram_refresh_seq.sv
// DRAM power-up and refresh sequencer (top).
// The block works through these phases:
//   1. Waits PAUSE_CYC cycles after reset.
//   2. Issues WAKE_CYCLES refresh cycles, then raises ready.
//   3. Schedules one refresh every REF_INTERVAL cycles and arbitrates
//      the memory with a host request/grant pair.
// A refresh missing DEADLINE_CYC sets a sticky overrun flag and forces a
// replay of the wake-up burst after the host releases.
// Assumes: REF_INTERVAL exceeds one refresh cycle; DEADLINE_CYC > REF_INTERVAL;
// the host holds host_req high for the whole host cycle.
module dram_refresh_seq #(
    parameter int PAUSE_CYC     = 50000,
    parameter int WAKE_CYCLES   = 8,
    parameter int REF_INTERVAL  = 3900,
    parameter int DEADLINE_CYC  = 7800,
    parameter int RAS_LOW_CYC   = 15,
    parameter int CAS_LOW_CYC   = 5,
    parameter int CAS_LEAD_CYC  = 2,
    parameter int PRECHARGE_CYC = 10,
    parameter int ROWS          = 2048
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cbr_mode,
    input  logic                    host_req,
    output logic                    host_gnt,
    output logic                    ready,
    output logic                    overrun,
    output logic                    ras_n,
    output logic                    cas_n,
    output logic                    we_n,
    output logic [$clog2(ROWS)-1:0] row_addr
);
    import dref_pkg::*;

    localparam int ROW_W = $clog2(ROWS);
    localparam int PW    = $clog2(PAUSE_CYC + 1);
    localparam int SW    = $clog2(DEADLINE_CYC + 2);
    localparam int BW    = $clog2(WAKE_CYCLES + 1);

    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [SW-1:0] DUE_AT     = SW'(REF_INTERVAL - 1);
    localparam logic [SW-1:0] LATE_AT    = SW'(DEADLINE_CYC);
    localparam logic [BW-1:0] BURST_LEN  = BW'(WAKE_CYCLES);

    seq_state_t       state;
    logic [BW-1:0]    burst_left;
    logic [PW-1:0]    pause_cnt;
    logic [SW-1:0]    since_ref;
    logic             due;
    logic             late;
    logic             cg_start;
    logic             cg_busy;
    logic             cg_done;
    logic             cg_cbr;
    logic [ROW_W-1:0] cur_row;
    logic             ready_state;

    // Pause timer: runs only in the stabilisation phase.
    dref_sat_counter #(.WIDTH(PW)) u_pause_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_PAUSE),
        .en    (1'b1),
        .count (pause_cnt)
    );

    // Refresh-age timer: cycles since the last refresh start.
    dref_sat_counter #(.WIDTH(SW)) u_age_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cg_start || (state == ST_WAKE)),
        .en    (1'b1),
        .count (since_ref)
    );

    // Row pointer for row-only refresh; column-before-row leaves it alone.
    dref_row_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cg_done && !cg_cbr),
        .row   (cur_row)
    );

    // Strobe generator for single refresh cycles.
    dref_cycle_gen #(
        .RAS_LOW_CYC   (RAS_LOW_CYC),
        .CAS_LOW_CYC   (CAS_LOW_CYC),
        .CAS_LEAD_CYC  (CAS_LEAD_CYC),
        .PRECHARGE_CYC (PRECHARGE_CYC),
        .ROW_W         (ROW_W)
    ) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cg_start),
        .cbr      (cbr_mode),
        .row_in   (cur_row),
        .busy     (cg_busy),
        .done     (cg_done),
        .kind_cbr (cg_cbr),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .row_out  (row_addr)
    );

    assign due  = (since_ref >= DUE_AT);
    assign late = (since_ref >= LATE_AT);

    // Refresh launch: back-to-back in the burst, on schedule when ready.
    assign cg_start = ((state == ST_WAKE) && !cg_busy)
                   || ((state == ST_RUN) && !overrun && due);

    // Phase sequencing, burst counting and the sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PAUSE;
            burst_left <= '0;
            overrun    <= 1'b0;
        end else begin
            unique case (state)
                ST_PAUSE: begin
                    if (pause_cnt == PAUSE_LAST) begin
                        state      <= ST_WAKE;
                        burst_left <= BURST_LEN;
                    end
                end
                ST_WAKE: begin
                    if (cg_done) begin
                        burst_left <= burst_left - 1'b1;
                        if (burst_left == BW'(1)) begin
                            state   <= ST_RUN;
                            overrun <= 1'b0;
                        end
                    end
                end
                ST_RUN: begin
                    if (overrun) begin
                        state      <= ST_WAKE;
                        burst_left <= BURST_LEN;
                    end else if (due) begin
                        state <= ST_REFRESH;
                    end else if (host_req) begin
                        state <= ST_HOST;
                    end
                end
                ST_HOST: begin
                    if (!host_req) begin
                        state <= ST_RUN;
                    end
                end
                ST_REFRESH: begin
                    if (cg_done) begin
                        state <= ST_RUN;
                    end
                end
                default: state <= ST_PAUSE;
            endcase
            if (((state == ST_RUN) || (state == ST_HOST)) && late) begin
                overrun <= 1'b1;
            end
        end
    end

    assign ready_state = (state == ST_RUN) || (state == ST_HOST) || (state == ST_REFRESH);
    assign ready       = ready_state && !overrun;
    assign host_gnt    = (state == ST_HOST);
    assign we_n        = 1'b1;

    AST_PAUSE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE) |-> (ras_n && cas_n && !ready));       // R1
    AST_GRANT_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_gnt) |-> $past(ready));                         // R8
    AST_GRANT_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> (ras_n && cas_n));                            // R8
    AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && !host_req) |=> !host_gnt);                    // R8
    AST_NO_GRANT_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_gnt) |-> $past(!due));                          // R9
    AST_OVERRUN_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> ready);                                 // R10

endmodule

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;

    localparam int PAUSE    = 300;
    localparam int WAKE     = 8;
    localparam int INTERVAL = 100;
    localparam int DEADLINE = 250;
    localparam int RAS_LOW  = 4;
    localparam int CAS_LOW  = 3;
    localparam int CAS_LEAD = 1;
    localparam int PRE      = 2;
    localparam int ROWS     = 8;
    localparam int ROW_W    = $clog2(ROWS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cbr_mode = 1'b0;
    logic             host_req = 1'b0;
    logic             host_gnt;
    logic             ready;
    logic             overrun;
    logic             ras_n;
    logic             cas_n;
    logic             we_n;
    logic [ROW_W-1:0] row_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC     (PAUSE),
        .WAKE_CYCLES   (WAKE),
        .REF_INTERVAL  (INTERVAL),
        .DEADLINE_CYC  (DEADLINE),
        .RAS_LOW_CYC   (RAS_LOW),
        .CAS_LOW_CYC   (CAS_LOW),
        .CAS_LEAD_CYC  (CAS_LEAD),
        .PRECHARGE_CYC (PRE),
        .ROWS          (ROWS)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cbr_mode (cbr_mode),
        .host_req (host_req),
        .host_gnt (host_gnt),
        .ready    (ready),
        .overrun  (overrun),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .row_addr (row_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int next_row(input int r);
        return (r == ROWS - 1) ? 0 : r + 1;
    endfunction

    // Pin monitor: pulse widths, ordering, row sequence and grant rules.
    int cyc, n_falls, last_fall, prev_fall, exp_row, ras_run, cas_run;
    bit ras_prev, cas_prev, ready_prev, gnt_prev, cur_cbr, cas_seen;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; n_falls = 0; last_fall = 0; prev_fall = 0; exp_row = 0;
            ras_run = 0; cas_run = 0; ras_prev = 1; cas_prev = 1;
            ready_prev = 0; gnt_prev = 0; cur_cbr = 0; cas_seen = 0;
        end else begin
            cyc++;
            if (!ras_n) ras_run++;
            if (!cas_n) cas_run++;
            if (!ras_n && ras_prev) begin
                n_falls++;
                prev_fall = last_fall;
                last_fall = cyc;
                chk(we_n == 1'b1, "R6", int'(we_n), 1);
                if (n_falls == 1) chk(cyc >= PAUSE, "R1", cyc, PAUSE);
                if (!cas_n) begin
                    cur_cbr = 1;
                    chk(cas_run - 1 == CAS_LEAD, "R4", cas_run - 1, CAS_LEAD);
                    chk(row_addr == '0, "R4", int'(row_addr), 0);
                end else begin
                    cur_cbr = 0;
                    cas_seen = 0;
                    chk(int'(row_addr) == exp_row, "R5", int'(row_addr), exp_row);
                    exp_row = next_row(exp_row);
                end
            end
            if (!ras_n && !cur_cbr && !cas_n) cas_seen = 1;
            if (ras_n && !ras_prev) begin
                chk(ras_run == RAS_LOW, cur_cbr ? "R4" : "R3", ras_run, RAS_LOW);
                if (!cur_cbr) chk(!cas_seen, "R3", int'(cas_seen), 0);
                ras_run = 0;
            end
            if (cas_n && !cas_prev) begin
                chk(cas_run == CAS_LOW, "R4", cas_run, CAS_LOW);
                cas_run = 0;
            end
            if (host_gnt && !gnt_prev) chk(ready_prev, "R8", int'(ready_prev), 1);
            if (host_gnt) chk(ras_n && cas_n, "R8", int'({ras_n, cas_n}), 3);
            ras_prev = ras_n; cas_prev = cas_n; ready_prev = ready; gnt_prev = host_gnt;
        end
    end

    task automatic report_and_end();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", 0, 1);
        report_and_end();
    end

    task automatic wait_gnt(input int lim, output bit ok);
        ok = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (host_gnt) begin ok = 1; break; end
        end
    endtask

    task automatic wait_ready(input int lim, output bit ok);
        ok = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (ready) begin ok = 1; break; end
        end
    endtask

    task automatic wait_falls(input int target, input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (n_falls >= target) break;
        end
    endtask

    // One host cycle: request, hold, release, check release timing.
    task automatic host_cycle(input int hold);
        bit ok;
        host_req = 1'b1;
        wait_gnt(400, ok);
        chk(ok, "R8", int'(ok), 1);
        repeat (hold) @(negedge clk);
        chk(host_gnt, "R8", int'(host_gnt), 1);
        host_req = 1'b0;
        @(negedge clk);
        chk(!host_gnt, "R8", int'(host_gnt), 0);
    endtask

    initial begin
        bit ok;
        int mark;
        void'($urandom(32'd20240611));
        // Reset state (R1)
        repeat (3) @(negedge clk);
        chk(!ready && !host_gnt && !overrun, "R1", int'({ready, host_gnt, overrun}), 0);
        chk(ras_n && cas_n && we_n, "R1", int'({ras_n, cas_n, we_n}), 7);
        rst_n = 1'b1;
        repeat (PAUSE / 2) @(negedge clk);
        chk(!ready && ras_n && cas_n, "R1", int'({ready, ras_n, cas_n}), 3);

        // Wake-up burst (R2)
        wait_ready(PAUSE + 500, ok);
        chk(ok, "R2", int'(ok), 1);
        chk(n_falls == WAKE, "R2", n_falls, WAKE);

        // Idle refresh spacing, row-only (R7)
        mark = n_falls;
        wait_falls(mark + 3, 1000);
        chk(last_fall - prev_fall == INTERVAL, "R7", last_fall - prev_fall, INTERVAL);

        // Column-before-row refreshes and spacing (R4, R7)
        cbr_mode = 1'b1;
        mark = n_falls;
        wait_falls(mark + 3, 1000);
        chk(last_fall - prev_fall == INTERVAL, "R7", last_fall - prev_fall, INTERVAL);
        // Back to row-only: row sequence resumes where it stopped (R5)
        cbr_mode = 1'b0;
        mark = n_falls;
        wait_falls(mark + 2, 1000);

        // Directed host cycle (R8)
        host_cycle(20);

        // Refresh due during host cycle wins over a new request (R9)
        host_req = 1'b1;
        wait_gnt(400, ok);
        repeat (INTERVAL + 10) @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        mark = n_falls;
        host_req = 1'b1;
        wait_gnt(400, ok);
        chk(ok, "R9", int'(ok), 1);
        chk(n_falls > mark, "R9", n_falls - mark, 1);
        host_req = 1'b0;
        @(negedge clk);

        // Random host traffic and refresh styles within the deadline (R8, R10)
        for (int i = 0; i < 30; i++) begin
            cbr_mode = 1'($urandom_range(0, 1));
            repeat ($urandom_range(0, 40)) @(negedge clk);
            host_cycle($urandom_range(1, 120));
            chk(!overrun, "R10", int'(overrun), 0);
        end
        cbr_mode = 1'b0;

        // Deadline overrun and wake-up replay (R10)
        host_req = 1'b1;
        wait_gnt(400, ok);
        repeat (DEADLINE + 50) @(negedge clk);
        chk(overrun, "R10", int'(overrun), 1);
        chk(!ready, "R10", int'(ready), 0);
        host_req = 1'b0;
        mark = n_falls;
        wait_ready(2000, ok);
        chk(ok, "R10", int'(ok), 1);
        chk(n_falls - mark == WAKE, "R10", n_falls - mark, WAKE);
        chk(!overrun, "R10", int'(overrun), 0);

        // One more scheduled refresh after replay (R5, R7)
        mark = n_falls;
        wait_falls(mark + 2, 1000);
        chk(last_fall - prev_fall == INTERVAL, "R7", last_fall - prev_fall, INTERVAL);

        report_and_end();
    end

endmodule